// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block connects a clocked host port to an external asynchronous static RAM of 512K words by 24 bits. The RAM has no common chip enable. It is split into three 8-bit byte lanes, and each lane has its own active-low select. The controller turns a host lane mask directly into those three selects. A host issues one access at a time through a valid/ready handshake. The access carries a read/write flag, a word address, write data and a lane mask. The controller finishes every accepted access with a one-cycle done pulse. For a read, the pulse comes with the returned word.

A write goes through four phases: a setup cycle, a write-enable pulse that lasts a parameterised number of cycles, a hold cycle, and a completion cycle. A read keeps the address, the selects and output enable low for a parameterised number of cycles, which must cover the access time of the memory, and samples the bus on the last of those cycles. The controller drives the shared data bus only while write enable is low. Every path into a read passes through cycles in which write enable is high and the bus is released, so the controller and the memory never drive the bus at the same time. The reset input is asynchronous on assertion, and its release is synchronised to the clock inside the block.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held, and until two clock edges after it is released, all three lane selects, write enable and output enable are high, the bus is released, req_ready is low and rsp_done is low. Asserting reset during the setup cycle of a write aborts it, and memory is left unchanged.
- R2: req_ready is high only while the controller is idle. A request is accepted on a clock edge where req_valid and req_ready are both high, and req_ready stays low from the edge of acceptance until the access has completed.
- R3: Mask bit i drives lane select i, and lane select i gates data bits 8i+7 down to 8i. A write changes only the lanes whose mask bit is 1.
- R4: A write presents the address and selects for one cycle with write enable high, then holds write enable low for WR_CYC cycles, then keeps the address and selects unchanged for one more cycle with write enable high. rsp_done is high in the cycle that follows.
- R5: The controller drives mem_dq with the write data only while mem_we_n is low, and mem_oe_n stays high for the whole write.
- R6: A read holds the selected lanes and mem_oe_n low, with mem_we_n high, for RD_CYC cycles. The bus is sampled in the last of these cycles, and rsp_done is high in the next cycle with the word on rsp_rdata.
- R7: Read lanes whose mask bit is 0 are returned as zero on rsp_rdata.
- R8: mem_oe_n only falls when, in the cycle before, mem_we_n was high and the controller was not driving the bus.
- R9: A request with mask 000 still completes with its done pulse. No lane select goes low, a write changes nothing, and a read returns zero.
- R10: rsp_done is high for exactly one cycle for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (19) | Word address |
| req_wdata | input | DATA_W (24) | Write data |
| req_lanes | input | LANES (3) | Lane mask, bit i enables bits 8i+7:8i |
| rsp_rdata | output | DATA_W (24) | Read data, valid while rsp_done is high |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W (19) | Memory address |
| mem_lane_n | output | LANES (3) | Active-low lane selects |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq | inout | DATA_W (24) | Shared data bus |

## Verification
Full-word writes and reads at the lowest and highest addresses show that the address reaches the memory unaltered and that all three lanes are used. Single-lane writes to one word, one for each lane, then read back in full, show whether each mask bit reaches its own select and whether the other lanes are protected. Partial-mask reads separate correct zeroing of unselected lanes from a read that returns them. Mask-zero requests and an abort by reset during write setup show that a request reaches the array only through a selected lane while write enable is low. Every access is traced cycle by cycle against the expected phase pattern.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  // Access phases; order is not decoded outside the sequencer.
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WR_SETUP  = 3'd1,
    ST_WR_PULSE  = 3'd2,
    ST_WR_HOLD   = 3'd3,
    ST_RD_ACCESS = 3'd4,
    ST_FINISH    = 3'd5
  } seq_state_e;

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int CNT_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;

  always_comb begin
    cnt_en  = load || (cnt_q != '0);
    cnt_nxt = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_lane_pkg::*;
#(
  parameter int RD_CYC = 2,
  parameter int WR_CYC = 2,
  parameter int CNT_W  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_expired,
  output seq_state_e       state_q,
  output seq_state_e       state_nxt,
  output logic             accept,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_value
);

  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYC - 1);

  always_comb begin
    state_nxt = state_q;
    accept    = 1'b0;
    tmr_load  = 1'b0;
    tmr_value = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (req_write) begin
            state_nxt = ST_WR_SETUP;
          end else begin
            state_nxt = ST_RD_ACCESS;
            tmr_load  = 1'b1;
            tmr_value = RD_LOAD;
          end
        end
      end
      ST_WR_SETUP: begin
        state_nxt = ST_WR_PULSE;
        tmr_load  = 1'b1;
        tmr_value = WR_LOAD;
      end
      ST_WR_PULSE: begin
        if (tmr_expired) state_nxt = ST_WR_HOLD;
      end
      ST_WR_HOLD:   state_nxt = ST_FINISH;
      ST_RD_ACCESS: begin
        if (tmr_expired) state_nxt = ST_FINISH;
      end
      ST_FINISH:    state_nxt = ST_IDLE;
      default:      state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_nxt;
    end
  end

endmodule

// File: rtl/sram_lane_path.sv
module sram_lane_path
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int LANES  = 3,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  seq_state_e        state_nxt,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_lanes,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_lane_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done
);

  // Held request
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  lanes_q;

  // Pin registers and their next values
  logic [ADDR_W-1:0] pin_addr_q, pin_addr_nxt;
  logic [LANES-1:0]  pin_lane_q, pin_lane_nxt;
  logic              pin_we_q, pin_we_nxt;
  logic              pin_oe_q, pin_oe_nxt;
  logic              drive_q, drive_nxt;
  logic              done_q, done_nxt;
  logic [DATA_W-1:0] rdata_q;

  logic [ADDR_W-1:0] sel_addr;
  logic [LANES-1:0]  sel_lanes;
  logic              busy_nxt;

  // Per-lane gating of the sampled bus
  logic [LANES-1:0][LANE_W-1:0] lane_rd;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_rd[i] = lanes_q[i] ? dq_in[i*LANE_W +: LANE_W] : '0;
  end

  always_comb begin
    sel_addr     = accept ? req_addr  : addr_q;
    sel_lanes    = accept ? req_lanes : lanes_q;
    busy_nxt     = (state_nxt == ST_WR_SETUP) || (state_nxt == ST_WR_PULSE) ||
                   (state_nxt == ST_WR_HOLD)  || (state_nxt == ST_RD_ACCESS);
    pin_addr_nxt = busy_nxt ? sel_addr : pin_addr_q;
    pin_lane_nxt = busy_nxt ? ~sel_lanes : '1;
    pin_we_nxt   = (state_nxt != ST_WR_PULSE);
    pin_oe_nxt   = (state_nxt != ST_RD_ACCESS);
    drive_nxt    = (state_nxt == ST_WR_PULSE);
    done_nxt     = (state_nxt == ST_FINISH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      lanes_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      lanes_q <= req_lanes;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_addr_q <= '0;
      pin_lane_q <= '1;
      pin_we_q   <= 1'b1;
      pin_oe_q   <= 1'b1;
      drive_q    <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      pin_addr_q <= pin_addr_nxt;
      pin_lane_q <= pin_lane_nxt;
      pin_we_q   <= pin_we_nxt;
      pin_oe_q   <= pin_oe_nxt;
      drive_q    <= drive_nxt;
      done_q     <= done_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= lane_rd;
    end
  end

  assign mem_addr   = pin_addr_q;
  assign mem_lane_n = pin_lane_q;
  assign mem_we_n   = pin_we_q;
  assign mem_oe_n   = pin_oe_q;
  assign dq_out     = wdata_q;
  assign dq_oe      = drive_q;
  assign rsp_rdata  = rdata_q;
  assign rsp_done   = done_q;

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int LANES  = 3,
  parameter int LANE_W = 8,
  parameter int RD_CYC = 2,
  parameter int WR_CYC = 2,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_lanes,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_lane_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  inout  wire  [DATA_W-1:0] mem_dq
);

  localparam int MAX_WAIT = ((RD_CYC > WR_CYC) ? RD_CYC : WR_CYC) - 1;
  localparam int CNT_W    = (MAX_WAIT < 1) ? 1 : $clog2(MAX_WAIT + 1);

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_n_int = rst_pipe[1];

  seq_state_e        state_q;
  seq_state_e        state_nxt;
  logic              accept;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_value;
  logic              tmr_expired;
  logic              capture;
  logic [DATA_W-1:0] dq_out;
  logic              dq_oe;
  logic              valid_gated;

  assign valid_gated = req_valid && rst_n_int;
  assign req_ready   = (state_q == ST_IDLE) && rst_n_int;
  assign capture     = (state_q == ST_RD_ACCESS) && tmr_expired;

  sram_seq_fsm #(
    .RD_CYC (RD_CYC),
    .WR_CYC (WR_CYC),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .req_valid   (valid_gated),
    .req_write   (req_write),
    .tmr_expired (tmr_expired),
    .state_q     (state_q),
    .state_nxt   (state_nxt),
    .accept      (accept),
    .tmr_load    (tmr_load),
    .tmr_value   (tmr_value)
  );

  sram_wait_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (tmr_load),
    .load_val (tmr_value),
    .expired  (tmr_expired)
  );

  sram_lane_path #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_path (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .accept     (accept),
    .capture    (capture),
    .state_nxt  (state_nxt),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_lanes  (req_lanes),
    .dq_in      (mem_dq),
    .mem_addr   (mem_addr),
    .mem_lane_n (mem_lane_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .dq_out     (dq_out),
    .dq_oe      (dq_oe),
    .rsp_rdata  (rsp_rdata),
    .rsp_done   (rsp_done)
  );

  assign mem_dq = dq_oe ? dq_out : 'z;

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int ADDR_W = 19,
  parameter int LANES  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LANES-1:0]  mem_lane_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              dq_oe
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_we_n && mem_oe_n && (&mem_lane_n) && !dq_oe));

  p_busy_no_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !req_ready);

  p_we_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_lane_n)));

  p_we_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_lane_n)));

  p_drive_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!mem_we_n && mem_oe_n));

  p_no_enable_clash_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n);

  p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> ($past(mem_we_n) && !$past(dq_oe)));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .LANES  (LANES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_done   (rsp_done),
  .mem_addr   (mem_addr),
  .mem_lane_n (mem_lane_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .dq_oe      (dq_oe)
);

// File: tb/sram_lane_ctrl_tb.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb;

  localparam int RD_CYC = 2;
  localparam int WR_CYC = 2;
  localparam int NVEC   = 15;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [18:0] req_addr;
  logic [23:0] req_wdata;
  logic [2:0]  req_lanes;
  logic [23:0] rsp_rdata;
  logic        rsp_done;
  logic [18:0] mem_addr;
  logic [2:0]  mem_lane_n;
  logic        mem_we_n;
  logic        mem_oe_n;
  wire  [23:0] mem_dq;

  int n_chk = 0;
  int n_bad = 0;

  sram_lane_ctrl #(
    .ADDR_W (19), .LANES (3), .LANE_W (8), .RD_CYC (RD_CYC), .WR_CYC (WR_CYC)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
    .req_write (req_write), .req_addr (req_addr), .req_wdata (req_wdata),
    .req_lanes (req_lanes), .rsp_rdata (rsp_rdata), .rsp_done (rsp_done),
    .mem_addr (mem_addr), .mem_lane_n (mem_lane_n), .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n), .mem_dq (mem_dq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Behavioural memory: 64 tagged entries, indexed by low address bits.
  logic [23:0] m_word [64];
  logic [18:0] m_tag  [64];
  logic        m_vld  [64];
  logic [23:0] m_rd;
  logic [23:0] m_old;
  logic [5:0]  m_idx;

  initial begin
    for (int i = 0; i < 64; i++) m_vld[i] = 1'b0;
  end

  assign m_idx = mem_addr[5:0];

  always_comb begin
    if (!m_vld[m_idx])                m_rd = 24'h000000;
    else if (m_tag[m_idx] != mem_addr) m_rd = 24'hA5A5A5;
    else                               m_rd = m_word[m_idx];
  end

  for (genvar i = 0; i < 3; i++) begin : g_mlane
    assign mem_dq[i*8 +: 8] = (!mem_lane_n[i] && mem_we_n && !mem_oe_n) ? m_rd[i*8 +: 8] : 8'hzz;
  end

  always @(posedge clk) begin
    if (!mem_we_n && (mem_lane_n != 3'b111)) begin
      m_old = (m_vld[m_idx] && m_tag[m_idx] == mem_addr) ? m_word[m_idx] : 24'h0;
      for (int i = 0; i < 3; i++)
        if (!mem_lane_n[i]) m_old[i*8 +: 8] = mem_dq[i*8 +: 8];
      m_word[m_idx] <= m_old;
      m_tag[m_idx]  <= mem_addr;
      m_vld[m_idx]  <= 1'b1;
    end
  end

  // Reference contents
  logic [23:0] ref_mem [int];

  function automatic logic [23:0] lane_bits(input logic [2:0] m);
    return {{8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
  endfunction

  function automatic logic [23:0] ref_rd(input logic [18:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 24'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Vector: {write, addr[18:0], data[23:0], mask[2:0]}
  localparam logic [46:0] VEC [NVEC] = '{
    {1'b1, 19'h00000, 24'h123456, 3'b111},
    {1'b0, 19'h00000, 24'h000000, 3'b111},
    {1'b1, 19'h7FFFF, 24'hABCDEF, 3'b111},
    {1'b0, 19'h7FFFF, 24'h000000, 3'b111},
    {1'b1, 19'h00000, 24'hFF00FF, 3'b001},
    {1'b0, 19'h00000, 24'h000000, 3'b111},
    {1'b1, 19'h00000, 24'h770000, 3'b100},
    {1'b1, 19'h00000, 24'h00AA00, 3'b010},
    {1'b0, 19'h00000, 24'h000000, 3'b111},
    {1'b0, 19'h00000, 24'h000000, 3'b101},
    {1'b0, 19'h7FFFF, 24'h000000, 3'b010},
    {1'b1, 19'h2A5A1, 24'hFFFFFF, 3'b000},
    {1'b0, 19'h2A5A1, 24'h000000, 3'b111},
    {1'b0, 19'h00000, 24'h000000, 3'b000},
    {1'b0, 19'h12345, 24'h000000, 3'b111}
  };

  // One access, traced cycle by cycle after the accepting edge.
  task automatic access(input bit wr, input logic [18:0] a, input logic [23:0] d, input logic [2:0] m);
    int          len;
    bit          ok;
    bit          data_ok;
    logic [23:0] expv;
    logic        e_we, e_oe, e_done;
    logic [2:0]  e_lane;
    logic [31:0] fa, fe;
    expv    = ref_rd(a) & lane_bits(m);
    ok      = 1'b1;
    data_ok = 1'b1;
    fa      = 0;
    fe      = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_lanes = m;
    while (!req_ready) @(negedge clk);
    // R8: quiet bus in the cycle before the access starts
    chk(mem_we_n && mem_oe_n && (mem_lane_n == 3'b111), "R8 quiet before access",
        {mem_we_n, mem_oe_n, mem_lane_n}, 5'b11111);
    len = wr ? WR_CYC + 3 : RD_CYC + 1;
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (wr) begin
        e_we   = !(k >= 2 && k <= WR_CYC + 1);
        e_oe   = 1'b1;
        e_lane = (k <= WR_CYC + 2) ? ~m : 3'b111;
      end else begin
        e_we   = 1'b1;
        e_oe   = !(k <= RD_CYC);
        e_lane = (k <= RD_CYC) ? ~m : 3'b111;
      end
      e_done = (k == len);
      if (ok && ({mem_we_n, mem_oe_n, mem_lane_n, rsp_done, req_ready} !=
                 {e_we, e_oe, e_lane, e_done, 1'b0} ||
                 (k < len && mem_addr != a))) begin
        ok = 1'b0;
        fa = {k[7:0], 4'h0, mem_we_n, mem_oe_n, mem_lane_n, rsp_done, req_ready};
        fe = {k[7:0], 4'h0, e_we, e_oe, e_lane, e_done, 1'b0};
      end
      if (wr && !e_we && mem_dq !== d) data_ok = 1'b0;
    end
    if (wr) begin
      chk(ok, "R4 R2 write phases", fa, fe);
      chk(data_ok, "R5 write data on bus", mem_dq, d);
      ref_mem[int'(a)] = (ref_rd(a) & ~lane_bits(m)) | (d & lane_bits(m));
    end else begin
      chk(ok, "R6 R2 read phases", fa, fe);
      chk(rsp_rdata == expv, "R3 R7 R9 read data", rsp_rdata, expv);
    end
    @(negedge clk);
    chk(!rsp_done && req_ready, "R10 done single cycle", {rsp_done, req_ready}, 2'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_lanes = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!req_ready && !rsp_done, "R1 ready/done in reset", {req_ready, rsp_done}, 2'b00);
    chk(mem_we_n && mem_oe_n && mem_lane_n == 3'b111, "R1 pins in reset",
        {mem_we_n, mem_oe_n, mem_lane_n}, 5'b11111);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_ready, "R1 ready held during release", req_ready, 0);
    repeat (2) @(negedge clk);
    chk(req_ready, "R1 ready after release", req_ready, 1);

    for (int i = 0; i < NVEC; i++)
      access(VEC[i][46], VEC[i][45:27], VEC[i][26:3], VEC[i][2:0]);

    // R1: reset during write setup aborts the write
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00000;
    req_wdata = 24'h000000; req_lanes = 3'b111;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_we_n && mem_lane_n == 3'b000, "R4 setup cycle before abort",
        {mem_we_n, mem_lane_n}, 4'b1000);
    rst_n = 1'b0;
    #1;
    chk(mem_we_n && mem_oe_n && mem_lane_n == 3'b111 && !rsp_done && !req_ready,
        "R1 abort returns pins idle",
        {mem_we_n, mem_oe_n, mem_lane_n, rsp_done, req_ready}, 7'b1111100);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    access(1'b0, 19'h00000, 24'h0, 3'b111);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule